// File: doc/BRIEF.md
# Memory Controller Control and Status Register Bank

This block holds the software-visible configuration and fault-reporting state of an error-correcting memory controller. A simple word-oriented register port (select, write enable, byte address, write data, read data) reaches nine 32-bit registers. A build-time parameter picks one of three chip variants. The variant changes how writes to the enable register are masked and which enable bits survive a warm reset. On variant 0 only, a separate byte-wide, four-entry diagnostic window is also present.

The block keeps a fault status register, which a capture input from the checking logic fills in. Each capture records whether the error was correctable, the 8-bit syndrome, and whether it landed on top of an earlier error. A level interrupt is raised on uncorrectable errors, and on correctable errors when the enable register allows it. Any bus write to the fault status register clears the interrupt.

Two reset inputs are provided. The power-on reset clears everything and loads the variant code into the enable register. The warm reset keeps a variant-dependent set of enable bits.

Top module: `mcc_regbank`

## Requirements
- R1: Register index is addr_i[5:2]: 0 enable, 1 delay, 2 fault status, 3 video config, 4 fault address A, 5 fault address B, 6 diagnostic, 7 event count A, 8 event count B. Read data appears on rdata_o one cycle after a read is selected. Indexes 9 to 15 read as zero.
- R2: An enable write stores wdata & 0x00000103 on variant 0. On variants 1 and 2 it stores (variant << 28) | (wdata & 0x00000BFF).
- R3: After power-on reset the enable register holds the variant code in bits [31:28]: 0x00000000, 0x10000000 or 0x20000000. All other registers take their warm-reset defaults.
- R4: A warm reset keeps enable bit 8 on variant 0, and enable bits [31:24], [11] and [9:2] on variants 1 and 2. All other enable bits clear. Delay resets to 0x00000020, fault address A to 0x07C00000, and every other register to zero.
- R5: A delay write stores wdata & 0x7FFFFFFF, so bit 31 always reads zero.
- R6: Fault address A and B are read-only. Writes to indexes 4 and 5 leave their read values unchanged.
- R7: A fault status write stores the full word, and irq_o is low from the next cycle. A write in the same cycle as a capture wins, and the capture is dropped.
- R8: A correctable capture (cap_unc_i low) sets status bit 0 and loads cap_syn_i into bits [15:8]. It raises irq_o only when enable bit 1 is set.
- R9: An uncorrectable capture sets status bit 3, loads the syndrome into bits [15:8], and always raises irq_o one cycle later.
- R10: A capture that arrives while status bit 0 or bit 3 is already set also sets status bit 16.
- R11: On variant 0 the diagnostic window holds four bytes, indexed by daddr_i[1:0], with upper address bits ignored. Reads return on drdata_o one cycle later. On other variants the window reads zero and ignores writes.
- R12: Video config, diagnostic and both event count registers each store and return a full 32-bit word at their own index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | Warm reset, active low, asynchronous |
| sel_i | input | 1 | Register port select |
| we_i | input | 1 | Register port write enable |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, registered |
| dsel_i | input | 1 | Diagnostic window select |
| dwe_i | input | 1 | Diagnostic window write enable |
| daddr_i | input | 4 | Diagnostic window byte address |
| dwdata_i | input | 8 | Diagnostic window write data |
| drdata_o | output | 8 | Diagnostic window read data, registered |
| cap_i | input | 1 | Fault capture strobe |
| cap_unc_i | input | 1 | Capture is uncorrectable |
| cap_syn_i | input | 8 | Syndrome of the captured fault |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it. The read data for a read selected in one cycle is valid just after the next rising edge, on both ports. The bench's monitor notes which reads were issued at each rising edge and compares the results 2 ns after that edge, popping the expected words the driver queued. A capture or fault status write changes irq_o at that same edge, so interrupt checks sample at the following falling edge. Two instances, variant 0 and variant 1, receive the same stimulus and are checked against separate expected values.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 4;

  localparam logic [IDX_W-1:0] IX_ENA = 4'd0;
  localparam logic [IDX_W-1:0] IX_DLY = 4'd1;
  localparam logic [IDX_W-1:0] IX_FST = 4'd2;
  localparam logic [IDX_W-1:0] IX_VID = 4'd3;
  localparam logic [IDX_W-1:0] IX_FAA = 4'd4;
  localparam logic [IDX_W-1:0] IX_FAB = 4'd5;
  localparam logic [IDX_W-1:0] IX_DGR = 4'd6;
  localparam logic [IDX_W-1:0] IX_EVA = 4'd7;
  localparam logic [IDX_W-1:0] IX_EVB = 4'd8;

  localparam logic [WORD_W-1:0] ENA_WMASK_V0  = 32'h0000_0103;
  localparam logic [WORD_W-1:0] ENA_WMASK_V12 = 32'h0000_0BFF;
  localparam logic [WORD_W-1:0] ENA_KEEP_V0   = 32'h0000_0100;
  localparam logic [WORD_W-1:0] ENA_KEEP_V12  = 32'hFF00_0BFC;
  localparam logic [WORD_W-1:0] DLY_WMASK     = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] DLY_RST       = 32'h0000_0020;
  localparam logic [WORD_W-1:0] FAA_RST       = 32'h07C0_0000;
  localparam logic [WORD_W-1:0] FAB_RST       = 32'h0000_0000;

  localparam int unsigned FST_CE  = 0;
  localparam int unsigned FST_UE  = 3;
  localparam int unsigned FST_SYN = 8;
  localparam int unsigned FST_ME  = 16;
  localparam int unsigned ENA_CEI = 1;

  function automatic logic [WORD_W-1:0] variant_code(int unsigned v);
    return WORD_W'(v[3:0]) << 28;
  endfunction

  function automatic logic [WORD_W-1:0] ena_keep(int unsigned v);
    return (v == 0) ? ENA_KEEP_V0 : ENA_KEEP_V12;
  endfunction

  function automatic logic [WORD_W-1:0] ena_wval(int unsigned v, logic [WORD_W-1:0] d);
    return (v == 0) ? (d & ENA_WMASK_V0) : (variant_code(v) | (d & ENA_WMASK_V12));
  endfunction
endpackage

// File: rtl/mcc_enable_reg.sv
module mcc_enable_reg
  import mcc_pkg::*;
#(
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] en_o
);
  localparam logic [WORD_W-1:0] KEEP = ena_keep(VARIANT);
  localparam logic [WORD_W-1:0] CODE = variant_code(VARIANT);

  logic [WORD_W-1:0] ret_q, vol_q, wval;

  assign wval = ena_wval(VARIANT, wdata_i);

  // retained bits: only power-on reset touches them
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)   ret_q <= CODE & KEEP;
    else if (wr_i) ret_q <= wval & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vol_q <= CODE & ~KEEP;
    else if (wr_i) vol_q <= wval & ~KEEP;
  end

  assign en_o = (ret_q & KEEP) | (vol_q & ~KEEP);
endmodule

// File: rtl/mcc_fault_status.sv
module mcc_fault_status
  import mcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic              cap_unc_i,
  input  logic [7:0]        cap_syn_i,
  input  logic              ce_irq_en_i,
  output logic [WORD_W-1:0] fsr_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] fsr_q;
  logic              irq_q;
  logic              busy;

  assign busy = fsr_q[FST_CE] | fsr_q[FST_UE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q <= '0;
      irq_q <= 1'b0;
    end else if (wr_i) begin
      fsr_q <= wdata_i;
      irq_q <= 1'b0;
    end else if (cap_i) begin
      fsr_q[FST_SYN +: 8] <= cap_syn_i;
      if (cap_unc_i) fsr_q[FST_UE] <= 1'b1;
      else           fsr_q[FST_CE] <= 1'b1;
      if (busy)      fsr_q[FST_ME] <= 1'b1;
      if (cap_unc_i || ce_irq_en_i) irq_q <= 1'b1;
    end
  end

  assign fsr_o = fsr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mcc_diag_window.sv
module mcc_diag_window #(
  parameter int unsigned AW    = 4,
  parameter int unsigned BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned BW = $clog2(BYTES);

  logic [7:0]    mem_q [BYTES];
  logic [7:0]    rd_q;
  logic [BW-1:0] ix;
  logic          unused_hi;

  assign ix        = addr_i[BW-1:0];
  assign unused_hi = ^addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else if (sel_i) begin
      if (we_i) mem_q[ix] <= wdata_i;
      else      rd_q      <= mem_q[ix];
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mcc_regbank.sv
module mcc_regbank
  import mcc_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DAW     = 4
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              dsel_i,
  input  logic              dwe_i,
  input  logic [DAW-1:0]    daddr_i,
  input  logic [7:0]        dwdata_i,
  output logic [7:0]        drdata_o,
  input  logic              cap_i,
  input  logic              cap_unc_i,
  input  logic [7:0]        cap_syn_i,
  output logic              irq_o
);
  logic              rst_all_n;
  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic [WORD_W-1:0] en_q, fsr_q, dly_q, vid_q, dgr_q, eva_q, evb_q;
  logic [WORD_W-1:0] rmux, rdata_q;
  logic              unused_addr;

  assign rst_all_n   = por_ni & rst_ni;
  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = sel_i & we_i;
  assign rd          = sel_i & ~we_i;

  mcc_enable_reg #(.VARIANT(VARIANT)) u_ena (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .rst_ni  (rst_all_n),
    .wr_i    (wr && idx == IX_ENA),
    .wdata_i (wdata_i),
    .en_o    (en_q)
  );

  mcc_fault_status u_fst (
    .clk_i       (clk_i),
    .rst_ni      (rst_all_n),
    .wr_i        (wr && idx == IX_FST),
    .wdata_i     (wdata_i),
    .cap_i       (cap_i),
    .cap_unc_i   (cap_unc_i),
    .cap_syn_i   (cap_syn_i),
    .ce_irq_en_i (en_q[ENA_CEI]),
    .fsr_o       (fsr_q),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      dly_q <= DLY_RST;
      vid_q <= '0;
      dgr_q <= '0;
      eva_q <= '0;
      evb_q <= '0;
    end else if (wr) begin
      unique case (idx)
        IX_DLY:  dly_q <= wdata_i & DLY_WMASK;
        IX_VID:  vid_q <= wdata_i;
        IX_DGR:  dgr_q <= wdata_i;
        IX_EVA:  eva_q <= wdata_i;
        IX_EVB:  evb_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      IX_ENA:  rmux = en_q;
      IX_DLY:  rmux = dly_q;
      IX_FST:  rmux = fsr_q;
      IX_VID:  rmux = vid_q;
      IX_FAA:  rmux = FAA_RST;
      IX_FAB:  rmux = FAB_RST;
      IX_DGR:  rmux = dgr_q;
      IX_EVA:  rmux = eva_q;
      IX_EVB:  rmux = evb_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) rdata_q <= '0;
    else if (rd)    rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  generate
    if (VARIANT == 0) begin : g_diag
      mcc_diag_window #(.AW(DAW), .BYTES(4)) u_diag (
        .clk_i   (clk_i),
        .rst_ni  (rst_all_n),
        .sel_i   (dsel_i),
        .we_i    (dwe_i),
        .addr_i  (daddr_i),
        .wdata_i (dwdata_i),
        .rdata_o (drdata_o)
      );
    end else begin : g_nodiag
      logic unused_diag;
      assign unused_diag = ^{dsel_i, dwe_i, daddr_i, dwdata_i};
      assign drdata_o    = '0;
    end
  endgenerate
endmodule

// File: rtl/mcc_regbank_chk.sv
module mcc_regbank_chk
  import mcc_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned ADDR_W  = 6
) (
  input logic              clk_i,
  input logic              por_ni,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              cap_i,
  input logic              cap_unc_i,
  input logic              irq_o,
  input logic [31:0]       fsr_i,
  input logic [31:0]       en_i
);
  logic [IDX_W-1:0] ix;
  logic             fst_wr;
  assign ix     = addr_i[ADDR_W-1:2];
  assign fst_wr = sel_i && we_i && ix == IX_FST;

  assert_unmapped_zero_R1: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (sel_i && !we_i && ix > IX_EVB) |=> rdata_o == 32'h0);

  assert_ena_write_R2: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (sel_i && we_i && ix == IX_ENA) |=> en_i == ena_wval(VARIANT, $past(wdata_i)));

  assert_dly_msb_R5: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (sel_i && !we_i && ix == IX_DLY) |=> !rdata_o[31]);

  assert_faa_const_R6: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (sel_i && !we_i && ix == IX_FAA) |=> rdata_o == FAA_RST);

  assert_fst_wr_clears_R7: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    fst_wr |=> !irq_o);

  assert_unc_raises_R9: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (cap_i && cap_unc_i && !fst_wr) |=> irq_o);

  assert_multi_err_R10: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (cap_i && !fst_wr && (fsr_i[FST_CE] || fsr_i[FST_UE])) |=> fsr_i[FST_ME]);
endmodule

bind mcc_regbank mcc_regbank_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .por_ni    (por_ni),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .cap_i     (cap_i),
  .cap_unc_i (cap_unc_i),
  .irq_o     (irq_o),
  .fsr_i     (fsr_q),
  .en_i      (en_q)
);

// File: tb/mcc_regbank_test.sv
module mcc_regbank_test;
  logic clk_i = 1'b0;
  always #4ns clk_i = ~clk_i;

  logic        por_ni = 1'b0, rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        dsel_i = 1'b0, dwe_i = 1'b0;
  logic [3:0]  daddr_i = '0;
  logic [7:0]  dwdata_i = '0;
  logic        cap_i = 1'b0, cap_unc_i = 1'b0;
  logic [7:0]  cap_syn_i = '0;
  logic [31:0] rd0, rd1;
  logic [7:0]  dr0, dr1;
  logic        irq0, irq1;

  mcc_regbank #(.VARIANT(0)) uut (
    .clk_i, .por_ni, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o(rd0),
    .dsel_i, .dwe_i, .daddr_i, .dwdata_i, .drdata_o(dr0),
    .cap_i, .cap_unc_i, .cap_syn_i, .irq_o(irq0));

  mcc_regbank #(.VARIANT(1)) uut_alt (
    .clk_i, .por_ni, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o(rd1),
    .dsel_i, .dwe_i, .daddr_i, .dwdata_i, .drdata_o(dr1),
    .cap_i, .cap_unc_i, .cap_syn_i, .irq_o(irq1));

  typedef struct {
    logic        diag;
    logic [31:0] e0;
    logic [31:0] e1;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read issued at this edge
  always @(posedge clk_i) begin : mon
    logic  rd, dr;
    item_t it;
    rd = sel_i && !we_i;
    dr = dsel_i && !dwe_i;
    #2ns;
    if (rd || dr) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=read expected=none");
      end else begin
        it = q.pop_front();
        if (it.diag) begin
          chk({it.tag, " v0"}, {24'h0, dr0}, it.e0);
          chk({it.tag, " v1"}, {24'h0, dr1}, it.e1);
        end else begin
          chk({it.tag, " v0"}, rd0, it.e0);
          chk({it.tag, " v1"}, rd1, it.e1);
        end
      end
    end
  end

  task automatic wr(int ix, logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1; we_i = 1; addr_i = 6'(ix << 2); wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; we_i = 0;
  endtask

  task automatic rd(int ix, logic [31:0] e0, logic [31:0] e1, string tag);
    item_t it;
    @(negedge clk_i);
    it.diag = 0; it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
    sel_i = 1; we_i = 0; addr_i = 6'(ix << 2) | 6'(ix & 3);
    @(negedge clk_i);
    sel_i = 0;
  endtask

  task automatic dwr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    dsel_i = 1; dwe_i = 1; daddr_i = a; dwdata_i = d;
    @(negedge clk_i);
    dsel_i = 0; dwe_i = 0;
  endtask

  task automatic drd(logic [3:0] a, logic [7:0] e0, string tag);
    item_t it;
    @(negedge clk_i);
    it.diag = 1; it.e0 = {24'h0, e0}; it.e1 = 32'h0; it.tag = tag;
    q.push_back(it);
    dsel_i = 1; dwe_i = 0; daddr_i = a;
    @(negedge clk_i);
    dsel_i = 0;
  endtask

  task automatic capture(logic unc, logic [7:0] syn);
    @(negedge clk_i);
    cap_i = 1; cap_unc_i = unc; cap_syn_i = syn;
    @(negedge clk_i);
    cap_i = 0; cap_unc_i = 0;
  endtask

  task automatic chk_irq(logic e, string tag);
    @(negedge clk_i);
    chk({tag, " irq v0"}, {31'h0, irq0}, {31'h0, e});
    chk({tag, " irq v1"}, {31'h0, irq1}, {31'h0, e});
  endtask

  task automatic defaults(string tag);
    rd(1, 32'h20, 32'h20, {tag, " delay"});
    rd(2, 0, 0, {tag, " fault status"});
    rd(3, 0, 0, {tag, " video"});
    rd(4, 32'h07C0_0000, 32'h07C0_0000, {tag, " fault addr A"});
    rd(5, 0, 0, {tag, " fault addr B"});
    rd(6, 0, 0, {tag, " diag reg"});
    rd(7, 0, 0, {tag, " event A"});
    rd(8, 0, 0, {tag, " event B"});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    por_ni = 1; rst_ni = 1;
    // R3: power-on contents
    rd(0, 32'h0, 32'h1000_0000, "R3 enable power-on");
    defaults("R3");
    chk_irq(0, "R3 reset");

    // R2: enable write masks
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_0103, 32'h1000_0BFF, "R2 enable all-ones");
    wr(0, 32'hA5A5_A5A5);
    rd(0, 32'h0000_0101, 32'h1000_01A5, "R2 enable pattern");

    // R5, R6, R12
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 delay msb");
    wr(4, 32'hDEAD_BEEF);
    wr(5, 32'h0000_1234);
    rd(4, 32'h07C0_0000, 32'h07C0_0000, "R6 fault addr A write ignored");
    rd(5, 0, 0, "R6 fault addr B write ignored");
    wr(3, 32'h1111_1111);
    wr(6, 32'h2222_2222);
    wr(7, 32'h3333_3333);
    wr(8, 32'h4444_4444);
    rd(3, 32'h1111_1111, 32'h1111_1111, "R12 video");
    rd(6, 32'h2222_2222, 32'h2222_2222, "R12 diag reg");
    rd(7, 32'h3333_3333, 32'h3333_3333, "R12 event A");
    rd(8, 32'h4444_4444, 32'h4444_4444, "R12 event B");
    rd(9, 0, 0, "R1 unmapped 9");
    rd(15, 0, 0, "R1 unmapped 15");

    // R4: warm reset keeps selected enable bits
    wr(0, 32'hFFFF_FFFF);
    wr(2, 32'h0000_00FF);
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    rd(0, 32'h0000_0100, 32'h1000_0BFC, "R4 enable kept bits");
    defaults("R4");

    // R8: correctable, interrupt disabled by enable bit 1
    capture(0, 8'h5A);
    chk_irq(0, "R8 masked");
    rd(2, 32'h0000_5A01, 32'h0000_5A01, "R8 status");
    wr(2, 0);
    wr(0, 32'h0000_0003);
    capture(0, 8'h3C);
    chk_irq(1, "R8 enabled");
    rd(2, 32'h0000_3C01, 32'h0000_3C01, "R8 status enabled");
    // R10: second capture on top of the first
    capture(1, 8'h77);
    rd(2, 32'h0001_7709, 32'h0001_7709, "R10 multiple errors");
    // R7: status write clears interrupt
    wr(2, 32'h0000_ABCD);
    chk_irq(0, "R7 cleared");
    rd(2, 32'h0000_ABCD, 32'h0000_ABCD, "R7 status stored");
    // R9: uncorrectable raises regardless of enable bit 1
    wr(2, 0);
    wr(0, 0);
    capture(1, 8'h81);
    chk_irq(1, "R9 uncorrectable");
    rd(2, 32'h0000_8108, 32'h0000_8108, "R9 status");

    // R11: diagnostic window
    dwr(4'd0, 8'h10);
    dwr(4'd1, 8'h20);
    dwr(4'd2, 8'h30);
    dwr(4'd3, 8'h40);
    dwr(4'd6, 8'h99);
    drd(4'd0, 8'h10, "R11 byte 0");
    drd(4'd1, 8'h20, "R11 byte 1");
    drd(4'd2, 8'h99, "R11 byte 2 aliased write");
    drd(4'd7, 8'h40, "R11 byte 3 aliased read");

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule